// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block produces the two edges a phase detector compares. The feedback path divides the input clock by a programmable total N. It uses a prescaler model whose modulus is either P or P+1, a B counter that counts prescaler cycles, and a swallow (A) counter. The A counter decides how many of those prescaler cycles use the longer modulus P+1. In dual-modulus operation N = P*B + A. In fixed-divide operation the swallow counter is held at zero and N = P*B. The output is a single-cycle pulse, once every N input cycles.

A companion reference divider counts enable ticks from the reference side. It emits a pulse after every R of them. An external sync input can restart the feedback counters, the reference counter, or both. A 2-bit select chooses which, and its zero value disables the sync. Settings are sampled only at a period boundary, so a change never produces a shortened or stretched period. An illegal dual-modulus setting raises an error flag and silences the feedback output.

Top module: `pswallow_div`

## Requirements
- R1: In fixed-divide mode (dual_en = 0) the feedback period is P*B input cycles. The p_code values 0..7 select P = 1, 2, 3, 4, 8, 16, 32, 64.
- R2: In dual-modulus mode (dual_en = 1) the period is P*B + A cycles. For example, P = 16, A = 7, B = 9 gives 151, and P = 2, A = 1, B = 3 gives 7.
- R3: Dual-modulus mode with A = 0 gives a period of P*B (P = 8, B = 25 gives 200).
- R4: P = 1 with B = 1 gives a period of one cycle, so fb_pulse stays high. P = 2 with B = 1 gives a pulse every second cycle.
- R5: In fixed-divide mode a_val has no effect on the period.
- R6: fb_pulse is one cycle wide when N > 1. After reset is released, its first assertion falls in input cycle N (sample index N-1, where sample index 0 is the first cycle out of reset). It then recurs every N cycles.
- R7: An illegal setting is dual_en = 1 with A > B, or B = 0. If the counters reload with an illegal setting, cfg_err is high from the next cycle and fb_pulse stays low. While the flag is set, the inputs are re-examined every cycle. Once they become legal, cfg_err clears on the next edge and a full period starts there.
- R8: A setting change made in the middle of a period takes effect only after the next fb_pulse.
- R9: sync_ctl = 2'b01 or 2'b11 with sync_in high restarts the feedback counters at the next edge. The next pulse then comes N cycles after that edge's cycle.
- R10: With sync_ctl = 2'b00, sync_in has no effect on either output.
- R11: ref_pulse is high for one cycle, in the cycle after the edge that samples the R-th ref_ce tick. An r_val of 0 acts as 1.
- R12: sync_ctl = 2'b10 or 2'b11 with sync_in high clears the reference tick count and suppresses ref_pulse in the next cycle. With 2'b10 the feedback schedule is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset; loads the settings |
| sync_in | input | 1 | External counter restart request |
| sync_ctl | input | 2 | Sync target: 00 none, 01 feedback, 10 reference, 11 both |
| dual_en | input | 1 | 1 selects dual-modulus mode, 0 fixed-divide |
| p_code | input | 3 | Prescaler modulus selector |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Prescaler cycle count B |
| ref_ce | input | 1 | Reference tick enable |
| r_val | input | 14 | Reference divide ratio R |
| fb_pulse | output | 1 | Feedback pulse, one per N cycles |
| ref_pulse | output | 1 | Reference pulse, one per R ticks |
| cfg_err | output | 1 | Illegal feedback setting flag |

## Verification
fb_pulse is decoded from registered counter state without a further register. It is therefore due N-1 cycles after the first out-of-reset cycle, or after the cycle following a load edge. ref_pulse and cfg_err come out of a flop, so each appears one cycle after the edge that caused it. The bench drives inputs just after the falling edge and samples one time unit later. Each sample is numbered from the first cycle out of reset or restart. Expected pulse positions are computed from those indices: a modular formula for the feedback path, and a running tick counter for the reference path.

// File: rtl/pswdiv_pkg.sv
package pswdiv_pkg;

    localparam int A_W  = 6;
    localparam int B_W  = 13;
    localparam int R_W  = 14;
    localparam int PC_W = 3;
    localparam int PM_W = 7;

    typedef struct packed {
        logic            dual;
        logic [PM_W-1:0] p;
        logic [A_W-1:0]  a;
        logic [B_W-1:0]  b;
    } fb_cfg_t;

    typedef enum logic [1:0] {
        SYNC_OFF = 2'b00,
        SYNC_FB  = 2'b01,
        SYNC_REF = 2'b10,
        SYNC_ALL = 2'b11
    } sync_sel_e;

    function automatic logic [PM_W-1:0] p_of(input logic [PC_W-1:0] code);
        case (code)
            3'd0:    return PM_W'(1);
            3'd1:    return PM_W'(2);
            3'd2:    return PM_W'(3);
            3'd3:    return PM_W'(4);
            3'd4:    return PM_W'(8);
            3'd5:    return PM_W'(16);
            3'd6:    return PM_W'(32);
            default: return PM_W'(64);
        endcase
    endfunction

    function automatic logic cfg_bad(input fb_cfg_t c);
        return (c.b == '0) || (c.dual && (B_W'(c.a) > c.b));
    endfunction

endpackage

// File: rtl/pswdiv_cfg.sv
module pswdiv_cfg
    import pswdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  fb_cfg_t         cfg_d,
    output logic            dual_q,
    output logic [PM_W-1:0] p_q,
    output logic            err_q
);
    // Shadow of the modulus settings; refreshed only at period boundaries.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            dual_q <= cfg_d.dual;
            p_q    <= cfg_d.p;
            err_q  <= cfg_bad(cfg_d);
        end
    end
endmodule

// File: rtl/pswdiv_core.sv
module pswdiv_core
    import pswdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            dual_d,
    input  logic [A_W-1:0]  a_d,
    input  logic [B_W-1:0]  b_d,
    input  logic            dual_q,
    input  logic [PM_W-1:0] p_q,
    output logic            term
);
    logic [PM_W-1:0] pre_cnt;
    logic [A_W-1:0]  a_rem;
    logic [B_W-1:0]  b_rem;
    logic [PM_W-1:0] mod_now;
    logic            pre_last;

    // Longer modulus while swallow cycles remain.
    always_comb begin
        mod_now  = (dual_q && (a_rem != '0)) ? p_q + PM_W'(1) : p_q;
        pre_last = (pre_cnt == mod_now - PM_W'(1));
        term     = pre_last && (b_rem == B_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            pre_cnt <= '0;
            b_rem   <= b_d;
            a_rem   <= dual_d ? a_d : '0;
        end else if (pre_last) begin
            pre_cnt <= '0;
            b_rem   <= b_rem - B_W'(1);
            if (a_rem != '0)
                a_rem <= a_rem - A_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PM_W'(1);
        end
    end
endmodule

// File: rtl/pswdiv_rdiv.sv
module pswdiv_rdiv
    import pswdiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic           ce,
    input  logic [R_W-1:0] r_in,
    output logic           pulse
);
    logic [R_W-1:0] r_sh;
    logic [R_W-1:0] cnt;
    logic [R_W-1:0] r_eff;
    logic           last;

    always_comb begin
        r_eff = (r_sh == '0) ? R_W'(1) : r_sh;
        last  = (cnt == r_eff - R_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            r_sh  <= r_in;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (ce) begin
                if (last) begin
                    cnt   <= '0;
                    r_sh  <= r_in;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt + R_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
    import pswdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_in,
    input  logic [1:0]      sync_ctl,
    input  logic            dual_en,
    input  logic [PC_W-1:0] p_code,
    input  logic [A_W-1:0]  a_val,
    input  logic [B_W-1:0]  b_val,
    input  logic            ref_ce,
    input  logic [R_W-1:0]  r_val,
    output logic            fb_pulse,
    output logic            ref_pulse,
    output logic            cfg_err
);
    fb_cfg_t         cfg_d;
    sync_sel_e       ssel;
    logic            sync_fb;
    logic            sync_ref;
    logic            term;
    logic            load_fb;
    logic            dual_q;
    logic [PM_W-1:0] p_q;
    logic            err_q;

    always_comb begin
        cfg_d.dual = dual_en;
        cfg_d.p    = p_of(p_code);
        cfg_d.a    = a_val;
        cfg_d.b    = b_val;
        ssel       = sync_sel_e'(sync_ctl);
        sync_fb    = sync_in && ((ssel == SYNC_FB) || (ssel == SYNC_ALL));
        sync_ref   = sync_in && ((ssel == SYNC_REF) || (ssel == SYNC_ALL));
        load_fb    = sync_fb || term || err_q;
    end

    pswdiv_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load_fb),
        .cfg_d  (cfg_d),
        .dual_q (dual_q),
        .p_q    (p_q),
        .err_q  (err_q)
    );

    pswdiv_core u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (load_fb),
        .dual_d (cfg_d.dual),
        .a_d    (cfg_d.a),
        .b_d    (cfg_d.b),
        .dual_q (dual_q),
        .p_q    (p_q),
        .term   (term)
    );

    pswdiv_rdiv u_rdiv (
        .clk     (clk),
        .rst     (rst),
        .restart (sync_ref),
        .ce      (ref_ce),
        .r_in    (r_val),
        .pulse   (ref_pulse)
    );

    assign fb_pulse = term && !err_q;
    assign cfg_err  = err_q;
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk
    import pswdiv_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            sync_in,
    input logic [1:0]      sync_ctl,
    input logic            dual_en,
    input logic [PC_W-1:0] p_code,
    input logic [A_W-1:0]  a_val,
    input logic [B_W-1:0]  b_val,
    input logic            ref_ce,
    input logic            fb_pulse,
    input logic            ref_pulse,
    input logic            cfg_err
);
    logic in_bad;
    logic in_unit;

    always_comb begin
        in_bad  = (b_val == '0) || (dual_en && (B_W'(a_val) > b_val));
        in_unit = (p_code == '0) && (b_val == B_W'(1)) && (!dual_en || (a_val == '0));
    end

    assert_err_silent_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !fb_pulse);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> $past(in_bad));

    assert_sync_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (sync_in && sync_ctl[0] && !in_unit) |=> !fb_pulse);

    assert_ref_needs_tick_R11: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> $past(ref_ce));

    assert_sync_ref_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (sync_in && sync_ctl[1]) |=> !ref_pulse);
endmodule

bind pswallow_div pswallow_div_chk u_chk (.*);

// File: tb/tb_pswallow_div.sv
module tb_pswallow_div;
    import pswdiv_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sync_in = 1'b0;
    logic [1:0]      sync_ctl = 2'b00;
    logic            dual_en = 1'b0;
    logic [PC_W-1:0] p_code = '0;
    logic [A_W-1:0]  a_val = '0;
    logic [B_W-1:0]  b_val = B_W'(4);
    logic            ref_ce = 1'b0;
    logic [R_W-1:0]  r_val = R_W'(3);
    logic            fb_pulse;
    logic            ref_pulse;
    logic            cfg_err;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pswallow_div dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic set_fb(input bit d, input int pc, input int a, input int b);
        dual_en = d;
        p_code  = PC_W'(pc);
        a_val   = A_W'(a);
        b_val   = B_W'(b);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sync_in = 1'b0;
        ref_ce = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    // Period test: first pulse at index N-1, three pulses, all at k*N-1.
    task automatic t_period(input string tag, input int n_exp);
        int first = -1;
        int cnt = 0;
        int bad = 0;
        do_reset();
        for (int idx = 0; idx < 3 * n_exp; idx++) begin
            if (fb_pulse) begin
                if (first < 0) first = idx;
                cnt++;
                if ((idx + 1) % n_exp != 0) bad++;
            end
            step();
        end
        check(first == n_exp - 1, {tag, " first pulse"}, first, n_exp - 1);
        check(cnt == 3, {tag, " pulse count"}, cnt, 3);
        check(bad == 0, {tag, " misplaced pulses"}, bad, 0);
    endtask

    task automatic t_reset_state();
        set_fb(0, 0, 0, 4);
        r_val = R_W'(3);
        do_reset();
        check(fb_pulse == 1'b0, "R6 reset fb_pulse", int'(fb_pulse), 0);
        check(ref_pulse == 1'b0, "R11 reset ref_pulse", int'(ref_pulse), 0);
        check(cfg_err == 1'b0, "R7 reset cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_error();
        int cnt = 0;
        int first = -1;
        set_fb(1, 3, 5, 3);
        do_reset();
        check(cfg_err == 1'b1, "R7 A>B flagged", int'(cfg_err), 1);
        for (int i = 0; i < 40; i++) begin
            if (fb_pulse) cnt++;
            step();
        end
        check(cnt == 0, "R7 no pulses in error", cnt, 0);
        a_val = A_W'(2);
        step();
        check(cfg_err == 1'b0, "R7 error clears", int'(cfg_err), 0);
        for (int idx = 0; idx < 20; idx++) begin
            if (fb_pulse && first < 0) first = idx;
            step();
        end
        check(first == 13, "R7 fresh period after clear", first, 13);
        set_fb(0, 1, 0, 0);
        do_reset();
        check(cfg_err == 1'b1, "R7 B=0 flagged", int'(cfg_err), 1);
    endtask

    task automatic t_change();
        int bad = 0;
        int cnt = 0;
        set_fb(0, 0, 0, 10);
        do_reset();
        for (int idx = 0; idx <= 25; idx++) begin
            bit exp_p;
            if (idx == 3) b_val = B_W'(4);
            exp_p = (idx == 9) || (idx > 9 && ((idx - 9) % 4 == 0));
            if (fb_pulse) cnt++;
            if (fb_pulse != exp_p) bad++;
            step();
        end
        check(bad == 0, "R8 change at boundary", bad, 0);
        check(cnt == 5, "R8 pulse count", cnt, 5);
    endtask

    task automatic t_sync_fb(input logic [1:0] ctl, input bit takes, input string tag);
        int bad = 0;
        set_fb(0, 0, 0, 10);
        sync_ctl = ctl;
        do_reset();
        for (int idx = 0; idx <= 26; idx++) begin
            bit exp_p;
            exp_p = takes ? (idx == 15 || idx == 25) : (idx == 9 || idx == 19);
            if (fb_pulse != exp_p) bad++;
            sync_in = (idx == 5);
            step();
        end
        sync_in = 1'b0;
        sync_ctl = 2'b00;
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_ref(input int r, input int sync_at, input logic [1:0] ctl, input string tag);
        int bad = 0;
        int fbad = 0;
        int cnt = 0;
        int pulses = 0;
        int r_eff;
        r_eff = (r == 0) ? 1 : r;
        set_fb(0, 0, 0, 10);
        r_val = R_W'(r);
        sync_ctl = ctl;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            bit ce;
            bit sy;
            bit exp_p;
            ce = (i % 2 == 0);
            sy = (i == sync_at);
            ref_ce = ce;
            sync_in = sy;
            step();
            exp_p = 1'b0;
            if (sy && ctl[1]) begin
                cnt = 0;
            end else if (ce) begin
                cnt++;
                if (cnt == r_eff) begin
                    exp_p = 1'b1;
                    cnt = 0;
                end
            end
            if (ref_pulse) pulses++;
            if (ref_pulse != exp_p) bad++;
            if (fb_pulse != (((i + 2) % 10) == 0)) fbad++;
        end
        ref_ce = 1'b0;
        sync_in = 1'b0;
        sync_ctl = 2'b00;
        check(bad == 0, {tag, " ref schedule"}, bad, 0);
        check(pulses > 0, {tag, " ref pulses seen"}, pulses, 1);
        check(fbad == 0, {tag, " fb schedule untouched"}, fbad, 0);
    endtask

    initial begin
        t_reset_state();
        set_fb(0, 0, 0, 5);   t_period("R1 fixed P1 B5", 5);
        set_fb(0, 3, 0, 10);  t_period("R1 fixed P4 B10", 40);
        set_fb(0, 2, 0, 7);   t_period("R1 fixed P3 B7", 21);
        set_fb(1, 5, 7, 9);   t_period("R2 dual P16 A7 B9", 151);
        set_fb(1, 1, 1, 3);   t_period("R2 dual P2 A1 B3", 7);
        set_fb(1, 4, 0, 25);  t_period("R3 dual P8 A0 B25", 200);
        set_fb(0, 0, 0, 1);   t_period("R4 P1 B1", 1);
        set_fb(0, 1, 0, 1);   t_period("R4 P2 B1", 2);
        set_fb(0, 1, 5, 3);   t_period("R5 fixed ignores A", 6);
        set_fb(0, 4, 0, 3);   t_period("R6 width and spacing", 24);
        t_error();
        t_change();
        t_sync_fb(2'b01, 1'b1, "R9 sync feedback");
        t_sync_fb(2'b11, 1'b1, "R9 sync all");
        t_sync_fb(2'b00, 1'b0, "R10 sync disabled");
        t_ref(3, -1, 2'b00, "R11 R=3");
        t_ref(0, -1, 2'b00, "R11 R=0 as 1");
        t_ref(4, 13, 2'b00, "R10 ref sync ignored");
        t_ref(4, 13, 2'b10, "R12 ref sync");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1_500_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule